// File: doc/BRIEF.md
# Multi-Sensor Thermal Threshold Interrupt Unit

This block watches up to sixteen temperature sensors. Each sensor delivers a 12-bit two's-complement code together with a one-cycle sample strobe. Every strobed sample from an enabled sensor is compared, as a signed value, against three limits held for that sensor: an upper trip point, a lower trip point and a critical trip point. Each crossing sets a sticky event bit.

Upper and lower events share one 32-bit event word, and critical events have a word of their own. Each event word has a mask register and a clear register. Two level-high interrupt lines are produced from the events that are pending and not masked. One line serves the upper and lower events and the other serves the critical events. The critical word also records two external single-cycle events: a watchdog bark and a measurement-cycle completion.

Software reaches the unit through a plain register port. A write is accepted on `reg_we`, and the read data is a combinational function of `reg_addr`. A per-sensor status word reports the last accepted temperature and the event flags. Its valid flag drops while a new sample is being stored. That flag also stays low until every enabled sensor has delivered at least one sample.

Top module: `thermal_thresh_irq`

## Requirements
- R1: After reset, the upper/lower mask reads 0xFFFFFFFF, both event words read 0, the ready register reads 0, and both interrupt outputs are low.
- R2: A strobed sample from an active sensor n whose signed value is greater than or equal to that sensor's upper limit sets bit 16+n of the upper/lower event word (offset 0x10) at the next clock edge.
- R3: A strobed sample from an active sensor n whose signed value is less than or equal to that sensor's lower limit sets bit n of the upper/lower event word.
- R4: A strobed sample from an active sensor n whose signed value is greater than or equal to its critical limit (offset 0x180+4n, bits 11:0) sets bit n of the critical event word (offset 0x20).
- R5: Event bits stay set until cleared. A bit stays at 0 while the matching bit of the clear register holds 1. This applies to offset 0x14 for upper/lower and offset 0x24 for critical. Software clears an event by writing 1 to the clear bit and then writing 0.
- R6: `irq_ul` is high exactly when a lower event in bits 15:0 is pending and unmasked with enable bit 0 set, or an upper event in bits 31:16 is pending and unmasked with enable bit 1 set. The enable register is at offset 0x04, and a mask bit of 1 at offset 0x18 suppresses the event.
- R7: `irq_crit` is high exactly when enable bit 2 is set and some critical event bit is set with its mask bit (offset 0x28) at 0. A pulse on `wdog_evt` sets bit 31 of the critical word, and a pulse on `cycle_evt` sets bit 30.
- R8: The status word of sensor n is at offset 0x200+4n. It holds the temperature in bits 11:0, the lower event in bit 17, the upper event in bit 18, the critical event in bit 19 and the valid flag in bit 21. The valid flag is 0 in the cycle after a sample is stored and 1 from the cycle after that.
- R9: Bit 3 of the ready register (offset 0x30) is 1 when the global enable is set and every active sensor has stored a sample. While that bit is 0, every status word's valid flag reads 0.
- R10: A sensor is active when bit 0 (global enable) and bit 3+n of the control word (offset 0x00) are both 1. Samples from inactive sensors neither set events nor change the stored temperature.
- R11: The limit word of sensor n is at offset 0x100+4n. It holds the lower limit in bits 11:0 and the upper limit in bits 23:12, and it reads back as written, masked to 24 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | NSENS | Per-sensor sample strobe |
| smp_code | input | NSENS*12 | Per-sensor temperature code, sensor n in bits 12n+11:12n |
| wdog_evt | input | 1 | Watchdog bark event pulse |
| cycle_evt | input | 1 | Measurement-cycle completion event pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Byte address of the register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_ul | output | 1 | Upper/lower interrupt, active high |
| irq_crit | output | 1 | Critical interrupt, active high |

## Verification
Directed samples are placed exactly on each limit and one step below it. These separate a correct greater-or-equal or less-or-equal test from a strict one. Negative limits are included, which exposes any unsigned comparison. Random codes against random per-sensor limits, with random masks and partial clears, show whether events land on the right bit for every sensor and whether sticky bits survive unrelated clears. Separate sequences cover the enable gating of each line, the first-round ready gating, and samples from disabled sensors.

// File: rtl/thr_pkg.sv
package thr_pkg;
  localparam int TW = 12;            // temperature code width
  localparam int EVW = 32;           // event word width
  localparam int PAGE_LSB = 6;       // 16 words of 4 bytes per page
  localparam int SIW = PAGE_LSB - 2; // word index width inside a page

  // word indices inside page 0
  localparam logic [SIW-1:0] IX_CTRL    = 4'd0;
  localparam logic [SIW-1:0] IX_IEN     = 4'd1;
  localparam logic [SIW-1:0] IX_UL_STAT = 4'd4;
  localparam logic [SIW-1:0] IX_UL_CLR  = 4'd5;
  localparam logic [SIW-1:0] IX_UL_MASK = 4'd6;
  localparam logic [SIW-1:0] IX_CR_STAT = 4'd8;
  localparam logic [SIW-1:0] IX_CR_CLR  = 4'd9;
  localparam logic [SIW-1:0] IX_CR_MASK = 4'd10;
  localparam logic [SIW-1:0] IX_READY   = 4'd12;

  // per-sensor pages
  localparam int PG_THR  = 4; // 0x100
  localparam int PG_CRIT = 6; // 0x180
  localparam int PG_STAT = 8; // 0x200

  localparam logic [TW-1:0] LIM_MAX = 12'h7FF;
  localparam logic [TW-1:0] LIM_MIN = 12'h800;

  function automatic logic code_at_least(input logic [TW-1:0] smp,
                                         input logic [TW-1:0] lim);
    return $signed(smp) >= $signed(lim);
  endfunction

  function automatic logic code_at_most(input logic [TW-1:0] smp,
                                        input logic [TW-1:0] lim);
    return $signed(smp) <= $signed(lim);
  endfunction
endpackage

// File: rtl/thr_sensor_slice.sv
module thr_sensor_slice
  import thr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          stb,
  input  logic [TW-1:0] code,
  input  logic [TW-1:0] lim_lo,
  input  logic [TW-1:0] lim_hi,
  input  logic [TW-1:0] lim_cr,
  output logic [TW-1:0] temp_q,
  output logic          valid_q,
  output logic          seen_q,
  output logic          ev_lo,
  output logic          ev_hi,
  output logic          ev_cr
);
  logic take;
  assign take  = stb & active;
  assign ev_hi = take & code_at_least(code, lim_hi);
  assign ev_lo = take & code_at_most(code, lim_lo);
  assign ev_cr = take & code_at_least(code, lim_cr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      temp_q  <= '0;
      valid_q <= 1'b0;
      seen_q  <= 1'b0;
    end else if (!active) begin
      valid_q <= 1'b0;
      seen_q  <= 1'b0;
    end else if (stb) begin
      temp_q  <= code;
      valid_q <= 1'b0;
      seen_q  <= 1'b1;
    end else if (seen_q) begin
      valid_q <= 1'b1;
    end
  end
endmodule

// File: rtl/thr_event_reg.sv
module thr_event_reg #(
  parameter int W = 32,
  parameter logic [W-1:0] MASK_RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_we,
  input  logic         mask_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] status_q,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] clr_q,
  output logic [W-1:0] pend
);
  assign pend = status_q & ~mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= MASK_RST;
      clr_q    <= '0;
    end else begin
      status_q <= (status_q | set_i) & ~clr_q;
      if (clr_we)  clr_q  <= wdata;
      if (mask_we) mask_q <= wdata;
    end
  end
endmodule

// File: rtl/thermal_thresh_irq.sv
module thermal_thresh_irq
  import thr_pkg::*;
#(
  parameter int NSENS = 16,
  parameter int AW = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NSENS-1:0]    smp_stb,
  input  logic [NSENS*TW-1:0] smp_code,
  input  logic                wdog_evt,
  input  logic                cycle_evt,
  input  logic                reg_we,
  input  logic [AW-1:0]       reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic                irq_ul,
  output logic                irq_crit
);
  localparam int CTRL_W = 3 + NSENS;
  localparam int PGW = AW - PAGE_LSB;
  localparam int HALF = EVW / 2;

  logic [CTRL_W-1:0] ctrl_q;
  logic [2:0]        ien_q;
  logic [2*TW-1:0]   thr_q  [NSENS];
  logic [TW-1:0]     crit_q [NSENS];

  logic [PGW-1:0] page;
  logic [SIW-1:0] idx;
  logic           aligned, pg0;
  assign page    = reg_addr[AW-1:PAGE_LSB];
  assign idx     = reg_addr[PAGE_LSB-1:2];
  assign aligned = (reg_addr[1:0] == 2'b00);
  assign pg0     = aligned && (page == '0);

  logic gen_en;
  logic [NSENS-1:0] active, seen_vec, valid_vec, ev_lo, ev_hi, ev_cr;
  logic [TW-1:0] temp_vec [NSENS];
  logic ready;

  assign gen_en = ctrl_q[0];
  assign active = ctrl_q[3 +: NSENS] & {NSENS{gen_en}};
  assign ready  = gen_en & (&(seen_vec | ~active));

  // register writes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ien_q  <= '0;
      for (int i = 0; i < NSENS; i++) begin
        thr_q[i]  <= {LIM_MAX, LIM_MIN};
        crit_q[i] <= LIM_MAX;
      end
    end else if (reg_we) begin
      if (pg0 && idx == IX_CTRL) ctrl_q <= reg_wdata[CTRL_W-1:0];
      if (pg0 && idx == IX_IEN)  ien_q  <= reg_wdata[2:0];
      for (int i = 0; i < NSENS; i++) begin
        if (aligned && page == PGW'(PG_THR) && idx == SIW'(i))
          thr_q[i] <= reg_wdata[2*TW-1:0];
        if (aligned && page == PGW'(PG_CRIT) && idx == SIW'(i))
          crit_q[i] <= reg_wdata[TW-1:0];
      end
    end
  end

  // per-sensor compare slices
  for (genvar g = 0; g < NSENS; g++) begin : g_slice
    thr_sensor_slice u_slice (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (active[g]),
      .stb    (smp_stb[g]),
      .code   (smp_code[g*TW +: TW]),
      .lim_lo (thr_q[g][TW-1:0]),
      .lim_hi (thr_q[g][2*TW-1:TW]),
      .lim_cr (crit_q[g]),
      .temp_q (temp_vec[g]),
      .valid_q(valid_vec[g]),
      .seen_q (seen_vec[g]),
      .ev_lo  (ev_lo[g]),
      .ev_hi  (ev_hi[g]),
      .ev_cr  (ev_cr[g])
    );
  end

  // event vectors
  logic [EVW-1:0] ul_set, cr_set;
  always_comb begin
    ul_set = '0;
    cr_set = '0;
    for (int i = 0; i < NSENS; i++) begin
      ul_set[i]        = ev_lo[i];
      ul_set[HALF + i] = ev_hi[i];
      cr_set[i]        = ev_cr[i];
    end
    cr_set[EVW-1] = wdog_evt;
    cr_set[EVW-2] = cycle_evt;
  end

  logic [EVW-1:0] ul_st, ul_mask, ul_clr, ul_pend;
  logic [EVW-1:0] cr_st, cr_mask, cr_clr, cr_pend;

  thr_event_reg #(.W(EVW), .MASK_RST({EVW{1'b1}})) u_ul_evt (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (ul_set),
    .clr_we  (reg_we && pg0 && idx == IX_UL_CLR),
    .mask_we (reg_we && pg0 && idx == IX_UL_MASK),
    .wdata   (reg_wdata),
    .status_q(ul_st),
    .mask_q  (ul_mask),
    .clr_q   (ul_clr),
    .pend    (ul_pend)
  );

  thr_event_reg #(.W(EVW), .MASK_RST('0)) u_cr_evt (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (cr_set),
    .clr_we  (reg_we && pg0 && idx == IX_CR_CLR),
    .mask_we (reg_we && pg0 && idx == IX_CR_MASK),
    .wdata   (reg_wdata),
    .status_q(cr_st),
    .mask_q  (cr_mask),
    .clr_q   (cr_clr),
    .pend    (cr_pend)
  );

  assign irq_ul   = (ien_q[0] & (|ul_pend[HALF-1:0]))
                  | (ien_q[1] & (|ul_pend[EVW-1:HALF]));
  assign irq_crit = ien_q[2] & (|cr_pend);

  // read path
  always_comb begin
    reg_rdata = '0;
    if (pg0) begin
      case (idx)
        IX_CTRL:    reg_rdata = 32'(ctrl_q);
        IX_IEN:     reg_rdata = 32'(ien_q);
        IX_UL_STAT: reg_rdata = ul_st;
        IX_UL_CLR:  reg_rdata = ul_clr;
        IX_UL_MASK: reg_rdata = ul_mask;
        IX_CR_STAT: reg_rdata = cr_st;
        IX_CR_CLR:  reg_rdata = cr_clr;
        IX_CR_MASK: reg_rdata = cr_mask;
        IX_READY:   reg_rdata = {28'd0, ready, 3'd0};
        default:    reg_rdata = '0;
      endcase
    end else if (aligned) begin
      for (int i = 0; i < NSENS; i++) begin
        if (idx == SIW'(i)) begin
          if (page == PGW'(PG_THR))  reg_rdata = 32'(thr_q[i]);
          if (page == PGW'(PG_CRIT)) reg_rdata = 32'(crit_q[i]);
          if (page == PGW'(PG_STAT))
            reg_rdata = {10'd0, valid_vec[i] & ready, 1'b0, cr_st[i],
                         ul_st[HALF + i], ul_st[i], 5'd0, temp_vec[i]};
        end
      end
    end
  end
endmodule

// File: rtl/thr_irq_checker.sv
module thr_irq_checker #(
  parameter int NSENS = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NSENS-1:0] smp_stb,
  input logic [NSENS-1:0] valid_vec,
  input logic [31:0]      ul_st,
  input logic [31:0]      ul_mask,
  input logic [31:0]      ul_clr,
  input logic [31:0]      cr_st,
  input logic [31:0]      cr_mask,
  input logic [31:0]      cr_clr,
  input logic [2:0]       ien_q,
  input logic             irq_ul,
  input logic             irq_crit,
  input logic             ready,
  input logic             gen_en
);
  // R5: an event bit not being cleared survives to the next cycle
  a_r5_ul_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((ul_st & ~ul_clr) != 0) |=>
      ((ul_st & $past(ul_st & ~ul_clr)) == $past(ul_st & ~ul_clr)));

  a_r5_cr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((cr_st & ~cr_clr) != 0) |=>
      ((cr_st & $past(cr_st & ~cr_clr)) == $past(cr_st & ~cr_clr)));

  // R6: the upper/lower line needs an unmasked pending event
  a_r6_ul_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ul |-> ((ul_st & ~ul_mask) != 0) && (ien_q[1:0] != 2'b00));

  // R7: the critical line needs its enable and an unmasked event
  a_r7_crit_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_crit |-> (ien_q[2] && ((cr_st & ~cr_mask) != 0)));

  // R8: valid flag is low in the cycle after a sample is taken
  a_r8_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb[0] |=> !valid_vec[0]);

  // R9: ready never shows while the unit is globally off
  a_r9_ready_gen: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> gen_en);
endmodule

bind thermal_thresh_irq thr_irq_checker #(.NSENS(NSENS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .smp_stb  (smp_stb),
  .valid_vec(valid_vec),
  .ul_st    (ul_st),
  .ul_mask  (ul_mask),
  .ul_clr   (ul_clr),
  .cr_st    (cr_st),
  .cr_mask  (cr_mask),
  .cr_clr   (cr_clr),
  .ien_q    (ien_q),
  .irq_ul   (irq_ul),
  .irq_crit (irq_crit),
  .ready    (ready),
  .gen_en   (gen_en)
);

// File: tb/tb_thermal_thresh_irq.sv
module tb_thermal_thresh_irq;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 16;
  localparam int AW = 10;

  localparam logic [AW-1:0] A_CTRL = 10'h000, A_IEN = 10'h004;
  localparam logic [AW-1:0] A_ULST = 10'h010, A_ULCLR = 10'h014, A_ULMSK = 10'h018;
  localparam logic [AW-1:0] A_CRST = 10'h020, A_CRCLR = 10'h024, A_CRMSK = 10'h028;
  localparam logic [AW-1:0] A_RDY = 10'h030;

  function automatic logic [AW-1:0] a_thr(int n);  return AW'(10'h100 + 4*n); endfunction
  function automatic logic [AW-1:0] a_crit(int n); return AW'(10'h180 + 4*n); endfunction
  function automatic logic [AW-1:0] a_stat(int n); return AW'(10'h200 + 4*n); endfunction

  // signed 12-bit comparisons, done through integers
  function automatic bit m_ge(logic [11:0] a, logic [11:0] b);
    int ia, ib;
    ia = a[11] ? int'(a) - 4096 : int'(a);
    ib = b[11] ? int'(b) - 4096 : int'(b);
    return ia >= ib;
  endfunction
  function automatic bit m_le(logic [11:0] a, logic [11:0] b);
    return m_ge(b, a);
  endfunction

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NS-1:0] smp_stb = '0;
  logic [NS*12-1:0] smp_code = '0;
  logic wdog_evt = 1'b0, cycle_evt = 1'b0;
  logic reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq_ul, irq_crit;

  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thermal_thresh_irq #(.NSENS(NS), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_code(smp_code),
    .wdog_evt(wdog_evt), .cycle_evt(cycle_evt), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_ul(irq_ul), .irq_crit(irq_crit)
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_now(logic [AW-1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_now(a, d);
  endtask

  task automatic sample(int s, logic [11:0] c);
    @(negedge clk);
    smp_stb[s] = 1'b1;
    smp_code[s*12 +: 12] = c;
    @(negedge clk);
    smp_stb = '0;
  endtask

  // bench model of limits and events
  logic [11:0] m_lo [NS];
  logic [11:0] m_hi [NS];
  logic [11:0] m_cr [NS];
  logic [31:0] m_ul, m_crw, m_umask;

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int seed;
    seed = $urandom(1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_ULMSK, d); chk(d == 32'hFFFF_FFFF, "R1 ul mask", d, 32'hFFFF_FFFF);
    rd(A_ULST, d);  chk(d == 0, "R1 ul status", d, 0);
    rd(A_CRST, d);  chk(d == 0, "R1 crit status", d, 0);
    rd(A_RDY, d);   chk(d == 0, "R1 ready", d, 0);
    chk(irq_ul == 0 && irq_crit == 0, "R1 irq lines", {30'd0, irq_ul, irq_crit}, 0);

    // R9 first round gating
    wr(A_CTRL, 32'h1 | (32'hFFFF << 3));
    for (int s = 0; s < NS - 1; s++) sample(s, 12'h000);
    rd(A_RDY, d);     chk(d == 0, "R9 ready before last sensor", d, 0);
    rd(a_stat(0), d); chk(d[21] == 0, "R9 valid hidden until ready", d, {d[31:22], 1'b0, d[20:0]});
    sample(NS - 1, 12'h000);
    rd(A_RDY, d);     chk(d == 32'h8, "R9 ready after last sensor", d, 32'h8);
    rd(a_stat(0), d); chk(d[21] == 1, "R9 valid shown once ready", d, d | 32'h0020_0000);

    // R8 valid timing and temperature field
    sample(2, 12'h123);
    rd_now(a_stat(2), d);
    chk(d[21] == 0 && d[11:0] == 12'h123, "R8 valid low right after store", d, 32'h123);
    rd(a_stat(2), d);
    chk(d == 32'h0020_0123, "R8 valid set one cycle later", d, 32'h0020_0123);

    // R11 limit word layout and readback
    wr(a_thr(5), 32'hAB0C_8F9C);
    rd(a_thr(5), d); chk(d == 32'h000C_8F9C, "R11 limit readback", d, 32'h000C_8F9C);
    wr(a_crit(5), 32'h0000_012C);

    // R2 R3 R4 boundaries: lower -100, upper 200, crit 300
    sample(5, 12'h0C7);
    rd(A_ULST, d); chk(d == 0, "R2 one below upper", d, 0);
    sample(5, 12'h0C8);
    rd(A_ULST, d); chk(d == 32'h0020_0000, "R2 equal to upper", d, 32'h0020_0000);
    sample(5, 12'hF9D);
    rd(A_ULST, d); chk(d == 32'h0020_0000, "R3 one above lower", d, 32'h0020_0000);
    sample(5, 12'hF9C);
    rd(A_ULST, d); chk(d == 32'h0020_0020, "R3 equal to lower", d, 32'h0020_0020);
    sample(5, 12'h12B);
    rd(A_CRST, d); chk(d == 0, "R4 one below critical", d, 0);
    sample(5, 12'h12C);
    rd(A_CRST, d); chk(d == 32'h20, "R4 equal to critical", d, 32'h20);
    rd(a_stat(5), d);
    chk(d == 32'h002E_012C, "R8 status word flags", d, 32'h002E_012C);

    // R6 mask and enable gating
    wr(A_IEN, 32'h3);
    rd(A_ULST, d); chk(irq_ul == 0, "R6 all masked", {31'd0, irq_ul}, 0);
    wr(A_ULMSK, ~32'h0020_0000);
    rd(A_ULST, d); chk(irq_ul == 1, "R6 upper unmasked", {31'd0, irq_ul}, 1);
    wr(A_IEN, 32'h1);
    rd(A_ULST, d); chk(irq_ul == 0, "R6 upper enable off", {31'd0, irq_ul}, 0);
    wr(A_ULMSK, ~32'h0000_0020);
    rd(A_ULST, d); chk(irq_ul == 1, "R6 lower via enable bit 0", {31'd0, irq_ul}, 1);

    // R5 clear protocol
    wr(A_ULCLR, 32'h0020_0000);
    sample(5, 12'h100);
    rd(A_ULST, d); chk(d == 32'h20, "R5 held clear blocks set", d, 32'h20);
    wr(A_ULCLR, 32'h0);
    rd(A_ULST, d); chk(d == 32'h20, "R5 other bit kept", d, 32'h20);
    sample(5, 12'h100);
    rd(A_ULST, d); chk(d == 32'h0020_0020, "R5 set again after release", d, 32'h0020_0020);

    // R7 critical line with external events
    wr(A_CRCLR, 32'hFFFF_FFFF); wr(A_CRCLR, 32'h0);
    wr(A_IEN, 32'h4);
    @(negedge clk); wdog_evt = 1'b1; @(negedge clk); wdog_evt = 1'b0;
    rd(A_CRST, d); chk(d == 32'h8000_0000, "R7 watchdog bit", d, 32'h8000_0000);
    chk(irq_crit == 1, "R7 crit line high", {31'd0, irq_crit}, 1);
    wr(A_CRMSK, 32'h8000_0000);
    rd(A_CRST, d); chk(irq_crit == 0, "R7 watchdog masked", {31'd0, irq_crit}, 0);
    @(negedge clk); cycle_evt = 1'b1; @(negedge clk); cycle_evt = 1'b0;
    rd(A_CRST, d); chk(d == 32'hC000_0000, "R7 cycle bit", d, 32'hC000_0000);
    chk(irq_crit == 1, "R7 cycle event raises line", {31'd0, irq_crit}, 1);

    // R10 inactive sensors
    wr(A_ULCLR, 32'hFFFF_FFFF); wr(A_ULCLR, 32'h0);
    wr(A_CTRL, 32'h1 | ((32'hFFFF & ~32'h80) << 3));
    sample(7, 12'h7FF);
    rd(A_ULST, d); chk(d == 0, "R10 disabled sensor no event", d, 0);
    rd(a_stat(7), d); chk(d[11:0] == 12'h000, "R10 disabled sensor temp kept", d, 0);
    wr(A_CTRL, 32'hFFFF << 3);
    sample(0, 12'h7FF);
    rd(A_ULST, d); chk(d == 0, "R10 global off no event", d, 0);
    rd(A_RDY, d);  chk(d == 0, "R9 ready low when global off", d, 0);

    // random phase
    wr(A_CTRL, 32'h1 | (32'hFFFF << 3));
    wr(A_CRMSK, 32'h0);
    wr(A_CRCLR, 32'hFFFF_FFFF); wr(A_CRCLR, 32'h0);
    wr(A_IEN, 32'h7);
    m_ul = 0; m_crw = 0;
    m_umask = $urandom;
    wr(A_ULMSK, m_umask);
    for (int s = 0; s < NS; s++) begin
      m_lo[s] = 12'($urandom); m_hi[s] = 12'($urandom); m_cr[s] = 12'($urandom);
      wr(a_thr(s), {8'd0, m_hi[s], m_lo[s]});
      wr(a_crit(s), {20'd0, m_cr[s]});
    end
    for (int it = 0; it < 240; it++) begin
      int s;
      logic [11:0] c;
      s = int'($urandom % NS);
      c = 12'($urandom);
      sample(s, c);
      if (m_ge(c, m_hi[s])) m_ul[16 + s] = 1'b1;
      if (m_le(c, m_lo[s])) m_ul[s] = 1'b1;
      if (m_ge(c, m_cr[s])) m_crw[s] = 1'b1;
      rd(A_ULST, d); chk(d == m_ul, "R2 R3 random upper/lower word", d, m_ul);
      rd(A_CRST, d); chk(d == m_crw, "R4 random critical word", d, m_crw);
      chk(irq_ul == ((m_ul & ~m_umask) != 0), "R6 random irq_ul",
          {31'd0, irq_ul}, {31'd0, (m_ul & ~m_umask) != 0});
      chk(irq_crit == (m_crw != 0), "R7 random irq_crit",
          {31'd0, irq_crit}, {31'd0, m_crw != 0});
      if (it % 16 == 15) begin
        logic [31:0] b;
        b = $urandom & m_ul;
        wr(A_ULCLR, b); wr(A_ULCLR, 32'h0);
        m_ul &= ~b;
        rd(A_ULST, d); chk(d == m_ul, "R5 random partial clear", d, m_ul);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule